// File: doc/BRIEF.md
# Two-Stage Instruction Fetch Sequencer

This block is the program-flow front end of a small 8-bit processor whose program store sits on a bus of its own, apart from data memory. It owns the program counter and drives it as the program memory address every cycle. The memory answers combinationally with a 12-bit word, and that word is captured into the instruction register at the next clock edge. The instruction register is what the execute stage works on. While the execute stage consumes one instruction, the next one is already being fetched.

The execute stage can redirect flow in four ways: a goto with a target, a call with a target, a return, or a direct write of the program counter (the counter also appears in data space). Any accepted redirect throws away the word already fetched. It puts a no-operation bubble in the instruction register and restarts fetch at the new address, so a branch costs two cycles. A call saves the address that follows it on a two-entry hardware stack, and a return pops that stack. Program memory depth is a parameter.

Top module: `fseq`

## Requirements
- R1: With no accepted redirect, each clock edge loads `ir` with the 12-bit word read at `imem_addr`, sets `ir_valid` to 1 and `ir_pc` to that address, and advances `imem_addr` by one.
- R2: The fetch address wraps from DEPTH-1 to 0.
- R3: A redirect request made while `ir_valid` is 1 is accepted at the clock edge. After that edge, `ir` is the no-operation word 12'h000, `ir_valid` is 0 and `imem_addr` equals the new address. One edge later the word at the new address is valid, so a branch costs two cycles.
- R4: Redirect requests made while `ir_valid` is 0 (during a bubble) are ignored, and fetch continues sequentially.
- R5: When several requests are made together, exactly one is taken, in the priority order return, then call, then goto, then program counter write.
- R6: An accepted call pushes `ir_pc`+1 (wrapped as in R2) and redirects to `call_target`. An accepted goto redirects to `br_target`, and an accepted write redirects to `pcw_data`.
- R7: The return stack holds two entries. A push while both are filled discards the older entry.
- R8: An accepted return redirects to the most recent entry, and the older entry moves up. Popping past the bottom returns the oldest entry again and raises no error.
- R9: During reset `ir` is 12'h000, `ir_valid` is 0 and `imem_addr` is DEPTH-1, and both stack entries are cleared to 0.
- R10: DEPTH selects 512, 1024 or 2048 words, and the address width is clog2(DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | AW | Program memory fetch address |
| imem_data | input | 12 | Program memory word at imem_addr |
| br_req | input | 1 | Goto request |
| br_target | input | AW | Goto target |
| call_req | input | 1 | Call request |
| call_target | input | AW | Call target |
| ret_req | input | 1 | Return request |
| pcw_req | input | 1 | Direct program counter write |
| pcw_data | input | AW | Value written to the program counter |
| ir | output | 12 | Instruction register |
| ir_valid | output | 1 | Instruction register holds a real fetched word |
| ir_pc | output | AW | Address of the word in ir |

## Verification
Two functions can meet in the same cycle: a push and a pop of the return stack, when a call and a return are requested together. Redirect requests can also coincide with a bubble. The bench provokes both with directed vectors and a long pseudo-random stream that raises several requests at once. A reference model in the bench applies the stated priority and stack rules and predicts `imem_addr`, `ir`, `ir_valid` and `ir_pc` after every edge. Later returns then reveal which stack operation won, because the bench compares each return target with the model.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int unsigned WORD_W = 12;
  localparam int unsigned MAX_AW = 11;
  localparam logic [WORD_W-1:0] NOP_WORD = 12'h000;

  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_RET  = 3'd1,
    SRC_CALL = 3'd2,
    SRC_GOTO = 3'd3,
    SRC_PCW  = 3'd4
  } src_e;

  // Next sequential address with wrap at the configured depth.
  function automatic logic [MAX_AW-1:0] wrap_inc(input logic [MAX_AW-1:0] a,
                                                 input int unsigned depth);
    logic [MAX_AW-1:0] top;
    top = MAX_AW'(depth - 1);
    if (a >= top) return '0;
    return a + 1'b1;
  endfunction

  // Priority among redirect requests; only a valid instruction may redirect.
  function automatic src_e pick_src(input logic valid, input logic ret,
                                    input logic call, input logic gt,
                                    input logic pcw);
    if (!valid) return SRC_SEQ;
    if (ret)    return SRC_RET;
    if (call)   return SRC_CALL;
    if (gt)     return SRC_GOTO;
    if (pcw)    return SRC_PCW;
    return SRC_SEQ;
  endfunction

endpackage

// File: rtl/fseq_stack.sv
module fseq_stack #(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);

  logic [AW-1:0] top_q;
  logic [AW-1:0] bot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q <= '0;
      bot_q <= '0;
    end else if (push) begin
      bot_q <= top_q;
      top_q <= push_addr;
    end else if (pop) begin
      top_q <= bot_q;
    end
  end

  assign top_addr = top_q;

  assert_push_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (bot_q == $past(top_q)) && (top_q == $past(push_addr)));

  assert_pop_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (top_q == $past(bot_q)) && $stable(bot_q));

endmodule

// File: rtl/fseq_pc.sv
module fseq_pc
  import fseq_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  src_e          src,
  input  logic [AW-1:0] br_target,
  input  logic [AW-1:0] call_target,
  input  logic [AW-1:0] pcw_data,
  input  logic [AW-1:0] pop_addr,
  output logic [AW-1:0] fetch_addr
);

  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;

  always_comb begin
    case (src)
      SRC_RET:  pc_d = pop_addr;
      SRC_CALL: pc_d = call_target;
      SRC_GOTO: pc_d = br_target;
      SRC_PCW:  pc_d = pcw_data;
      default:  pc_d = AW'(wrap_inc(MAX_AW'(pc_q), DEPTH));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= TOP_ADDR;
    else        pc_q <= pc_d;
  end

  assign fetch_addr = pc_q;

  assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_SEQ && fetch_addr != TOP_ADDR) |=>
      fetch_addr == AW'($past(fetch_addr) + 1'b1));

  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_SEQ && fetch_addr == TOP_ADDR) |=> fetch_addr == '0);

  assert_goto_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_GOTO) |=> fetch_addr == $past(br_target));

endmodule

// File: rtl/fseq_ireg.sv
module fseq_ireg
  import fseq_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word,
  input  logic [AW-1:0]     fetch_addr,
  output logic [WORD_W-1:0] ir,
  output logic              ir_valid,
  output logic [AW-1:0]     ir_pc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir       <= NOP_WORD;
      ir_valid <= 1'b0;
      ir_pc    <= '0;
    end else if (take) begin
      ir       <= NOP_WORD;
      ir_valid <= 1'b0;
    end else begin
      ir       <= word;
      ir_valid <= 1'b1;
      ir_pc    <= fetch_addr;
    end
  end

  assert_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!ir_valid && ir == NOP_WORD));

  assert_refill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_valid |=> ir_valid);

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> (ir == $past(word)) && (ir_pc == $past(fetch_addr)));

endmodule

// File: rtl/fseq.sv
module fseq
  import fseq_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [AW-1:0]     imem_addr,
  input  logic [WORD_W-1:0] imem_data,
  input  logic              br_req,
  input  logic [AW-1:0]     br_target,
  input  logic              call_req,
  input  logic [AW-1:0]     call_target,
  input  logic              ret_req,
  input  logic              pcw_req,
  input  logic [AW-1:0]     pcw_data,
  output logic [WORD_W-1:0] ir,
  output logic              ir_valid,
  output logic [AW-1:0]     ir_pc
);

  // R10: only the three supported depths elaborate.
  generate
    if (DEPTH != 512 && DEPTH != 1024 && DEPTH != 2048) begin : g_bad_depth
      $error("fseq: DEPTH must be 512, 1024 or 2048");
    end
  endgenerate

  src_e          src;
  logic          flow_take;
  logic          ev_push;
  logic          ev_pop;
  logic          ev_goto;
  logic          ev_pcw;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] stack_top;

  assign src       = pick_src(ir_valid, ret_req, call_req, br_req, pcw_req);
  assign flow_take = (src != SRC_SEQ);
  assign ev_push   = (src == SRC_CALL);
  assign ev_pop    = (src == SRC_RET);
  assign ev_goto   = (src == SRC_GOTO);
  assign ev_pcw    = (src == SRC_PCW);
  assign ret_addr  = AW'(wrap_inc(MAX_AW'(ir_pc), DEPTH));

  fseq_stack #(.AW(AW)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .pop       (ev_pop),
    .push_addr (ret_addr),
    .top_addr  (stack_top)
  );

  fseq_pc #(.DEPTH(DEPTH), .AW(AW)) u_pc (
    .clk         (clk),
    .rst_n       (rst_n),
    .src         (src),
    .br_target   (br_target),
    .call_target (call_target),
    .pcw_data    (pcw_data),
    .pop_addr    (stack_top),
    .fetch_addr  (imem_addr)
  );

  fseq_ireg #(.AW(AW)) u_ireg (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (flow_take),
    .word       (imem_data),
    .fetch_addr (imem_addr),
    .ir         (ir),
    .ir_valid   (ir_valid),
    .ir_pc      (ir_pc)
  );

  assert_one_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_push, ev_pop, ev_goto, ev_pcw}));

  assert_ret_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_valid && ret_req) |=> imem_addr == $past(stack_top));

  assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_valid |-> !flow_take);

  assert_call_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_valid && call_req && !ret_req) |=> imem_addr == $past(call_target));

endmodule

// File: tb/fseq_test.sv
`timescale 1ns/1ps
module fseq_test;

  localparam int unsigned DEPTH = 512;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [11:0]   imem_data;
  logic          br_req = 1'b0, call_req = 1'b0, ret_req = 1'b0, pcw_req = 1'b0;
  logic [AW-1:0] br_target = '0, call_target = '0, pcw_data = '0;
  logic [11:0]   ir;
  logic          ir_valid;
  logic [AW-1:0] ir_pc;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [11:0] word_at(input int unsigned a);
    return {1'b1, 11'((a * 13 + 5) % 2048)};
  endfunction

  assign imem_data = word_at(imem_addr);

  fseq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .br_req(br_req), .br_target(br_target), .call_req(call_req),
    .call_target(call_target), .ret_req(ret_req), .pcw_req(pcw_req),
    .pcw_data(pcw_data), .ir(ir), .ir_valid(ir_valid), .ir_pc(ir_pc)
  );

  // Reference model state
  int unsigned m_fetch, m_irpc, m_top, m_bot, m_cnt;
  logic [11:0] m_ir;
  bit          m_valid;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "imem_addr", int'(imem_addr), int'(m_fetch));
    chk(tag, "ir_valid", int'(ir_valid), int'(m_valid));
    chk(tag, "ir", int'(ir), int'(m_ir));
    if (m_valid) chk(tag, "ir_pc", int'(ir_pc), int'(m_irpc));
  endtask

  // One cycle: drive requests, model the edge, compare away from the edge.
  task automatic step(input bit r, input bit c, input bit g, input bit p,
                      input int unsigned ct, input int unsigned gt, input int unsigned pd);
    string tag;
    int unsigned tgt;
    int nreq;
    ret_req = r; call_req = c; br_req = g; pcw_req = p;
    call_target = AW'(ct); br_target = AW'(gt); pcw_data = AW'(pd);
    nreq = int'(r) + int'(c) + int'(g) + int'(p);
    tag = "R1";
    if (m_valid && nreq > 0) begin
      if (r) begin
        tgt = m_top; m_top = m_bot; tag = "R8";
        if (m_cnt > 0) m_cnt--;
      end else if (c) begin
        m_bot = m_top; m_top = (m_irpc + 1) % DEPTH; tgt = ct;
        tag = (m_cnt == 2) ? "R7" : "R6";
        if (m_cnt < 2) m_cnt++;
      end else if (g) begin
        tgt = gt; tag = "R3";
      end else begin
        tgt = pd; tag = "R6";
      end
      if (nreq > 1) tag = {tag, "/R5"};
      m_valid = 1'b0; m_ir = 12'h000; m_fetch = tgt;
    end else begin
      if (nreq > 0) tag = "R4";
      else if (m_fetch == DEPTH - 1) tag = "R2";
      m_ir = word_at(m_fetch); m_irpc = m_fetch; m_valid = 1'b1;
      m_fetch = (m_fetch + 1) % DEPTH;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R9: reset state
    repeat (2) @(negedge clk);
    chk("R9", "ir_valid", int'(ir_valid), 0);
    chk("R9", "ir", int'(ir), 0);
    chk("R9", "imem_addr", int'(imem_addr), DEPTH - 1);
    // R10: address width follows the depth
    chk("R10", "addr width", $bits(imem_addr), 9);
    m_fetch = DEPTH - 1; m_valid = 0; m_ir = 0; m_irpc = 0;
    m_top = 0; m_bot = 0; m_cnt = 0;
    rst_n = 1'b1;

    // R9 stack cleared: first return goes to 0
    idle(1);
    step(1, 0, 0, 0, 0, 0, 0);
    // R1/R2: full sequential sweep across the wrap
    idle(DEPTH + 10);

    // R6/R7/R8: three nested calls then four returns
    step(0, 1, 0, 0, 100, 0, 0); idle(3);
    step(0, 1, 0, 0, 200, 0, 0); idle(3);
    step(0, 1, 0, 0, 300, 0, 0); idle(3);
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, 0, 0, 0, 0); idle(2);
    end
    // R4: request during the bubble is ignored
    step(0, 0, 1, 0, 0, 50, 0);
    step(0, 0, 1, 0, 0, 77, 0);
    idle(2);
    // R5: combined requests
    step(1, 1, 1, 1, 10, 20, 30); idle(2);
    step(0, 1, 1, 1, 11, 21, 31); idle(2);
    step(0, 0, 1, 1, 12, 22, 32); idle(2);
    step(0, 0, 0, 1, 12, 22, 33); idle(2);
    // R6 call from the top address wraps the return address to 0
    step(0, 0, 1, 0, 0, DEPTH - 1, 0);
    idle(1);
    step(0, 1, 0, 0, 5, 0, 0); idle(2);
    step(1, 0, 0, 0, 0, 0, 0); idle(2);

    // Pseudo-random mixed stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[2:0] == 3'd0, lfsr[5:3] == 3'd1, lfsr[8:6] == 3'd2,
           lfsr[11:9] == 3'd3, (i * 7) % DEPTH, (i * 11 + 3) % DEPTH,
           (i * 29 + 1) % DEPTH);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule